// File: doc/BRIEF.md
# Pipeline Main Control Decoder

This block turns the 6-bit opcode field (instruction bits [31:26]) of the instruction sitting in the fetch/decode pipeline register into the nine control signals of a five-stage datapath. The signals leave the block as three packed groups, sized for the stage that consumes them: a 2-bit write-back group, a 3-bit memory-access group and a 4-bit execute group. The decode itself is purely combinational.

The decoder recognises register-to-register arithmetic, load word, store word, branch-on-equal and a dedicated no-operation opcode. Every opcode outside this set, including the no-operation opcode, yields all-zero controls, so an unknown instruction moves down the pipeline as a bubble. A registered copy of the three groups, which forms the control part of the decode/execute pipeline register, is also produced, cleared by an active-low asynchronous reset.

Top module: `op_ctrl_decoder`

## Requirements
- R1: Input is the 6-bit opcode; outputs are nine bits in three groups with fixed bit positions: write-back group {reg_write=bit1, mem_to_reg=bit0}, memory group {branch=bit2, mem_read=bit1, mem_write=bit0}, execute group {reg_dst=bit3, alu_op=bits[2:1], alu_src=bit0}.
- R2: Opcode 000000 (register arithmetic) gives write-back 10, memory 000, execute 1100 (reg_dst=1, alu_op=10, alu_src=0).
- R3: Opcode 100011 (load word) gives write-back 11, memory 010, execute 0001 (alu_op=00, alu_src=1).
- R4: Opcode 101011 (store word) gives write-back 00, memory 001, execute 0001.
- R5: Opcode 000100 (branch-on-equal) gives write-back 00, memory 100, execute 0010 (alu_op=01, alu_src=0).
- R6: Opcode 100000 (no-operation) drives all nine control bits to zero.
- R7: Every other opcode drives all nine control bits to zero.
- R8: The registered outputs equal the combinational groups sampled at the previous rising clock edge; while rst_ni is low they are zero, and they clear as soon as rst_ni falls.
- R9: mem_read and mem_write are never both set, and branch is never set together with reg_write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the registered copy |
| rst_ni | input | 1 | Active-low asynchronous reset of the registered copy |
| opcode_i | input | 6 | Instruction opcode field |
| wb_o | output | 2 | Write-back group, combinational |
| mem_o | output | 3 | Memory group, combinational |
| ex_o | output | 4 | Execute group, combinational |
| wb_q_o | output | 2 | Write-back group, registered |
| mem_q_o | output | 3 | Memory group, registered |
| ex_q_o | output | 4 | Execute group, registered |

## Verification
The bench sweeps all 64 opcodes so that near misses of the decoded codes, such as 100001 next to load word or 000101 next to branch, are checked to give zeros; a decoder that matched only some opcode bits would let those neighbours fire memory or register writes. The no-operation opcode 100000 gets its own checks, since a decoder treating bit 5 alone as "memory op" would wrongly enable a load or store there. The registered groups are compared one cycle late against the opcode presented at the prior edge, and reset is pulled low in mid-run, which catches a copy that lags by a wrong number of cycles or one cleared only synchronously.

// File: rtl/op_ctrl_pkg.sv
package op_ctrl_pkg;
  localparam int OPC_W = 6;
  localparam int WB_W  = 2;
  localparam int MEM_W = 3;
  localparam int EX_W  = 4;
  localparam int CTL_W = WB_W + MEM_W + EX_W;

  typedef logic [OPC_W-1:0] opc_t;

  localparam opc_t OPC_ALU   = 6'b000000;
  localparam opc_t OPC_LOAD  = 6'b100011;
  localparam opc_t OPC_STORE = 6'b101011;
  localparam opc_t OPC_BEQ   = 6'b000100;
  localparam opc_t OPC_NOP   = 6'b100000;

  typedef struct packed {
    logic reg_write;
    logic mem_to_reg;
  } wb_ctl_t;

  typedef struct packed {
    logic branch;
    logic mem_read;
    logic mem_write;
  } mem_ctl_t;

  typedef struct packed {
    logic       reg_dst;
    logic [1:0] alu_op;
    logic       alu_src;
  } ex_ctl_t;

  typedef enum logic [2:0] {
    CLS_NONE,
    CLS_ALU,
    CLS_LOAD,
    CLS_STORE,
    CLS_BRANCH
  } op_class_e;
endpackage

// File: rtl/op_classify.sv
module op_classify
  import op_ctrl_pkg::*;
(
  input  opc_t      opcode_i,
  output op_class_e class_o
);
  always_comb begin
    case (opcode_i)
      OPC_ALU:   class_o = CLS_ALU;
      OPC_LOAD:  class_o = CLS_LOAD;
      OPC_STORE: class_o = CLS_STORE;
      OPC_BEQ:   class_o = CLS_BRANCH;
      default:   class_o = CLS_NONE; // nop and unknown opcodes
    endcase
  end
endmodule

// File: rtl/ctl_encode.sv
module ctl_encode
  import op_ctrl_pkg::*;
(
  input  op_class_e class_i,
  output wb_ctl_t   wb_o,
  output mem_ctl_t  mem_o,
  output ex_ctl_t   ex_o
);
  always_comb begin
    wb_o  = '0;
    mem_o = '0;
    ex_o  = '0;
    unique case (class_i)
      CLS_ALU: begin
        wb_o.reg_write = 1'b1;
        ex_o.reg_dst   = 1'b1;
        ex_o.alu_op    = 2'b10;
      end
      CLS_LOAD: begin
        wb_o.reg_write  = 1'b1;
        wb_o.mem_to_reg = 1'b1;
        mem_o.mem_read  = 1'b1;
        ex_o.alu_src    = 1'b1;
      end
      CLS_STORE: begin
        mem_o.mem_write = 1'b1;
        ex_o.alu_src    = 1'b1;
      end
      CLS_BRANCH: begin
        mem_o.branch = 1'b1;
        ex_o.alu_op  = 2'b01;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ctl_stage.sv
module ctl_stage #(
  parameter int W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/op_ctrl_decoder.sv
module op_ctrl_decoder
  import op_ctrl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [OPC_W-1:0] opcode_i,
  output logic [WB_W-1:0]  wb_o,
  output logic [MEM_W-1:0] mem_o,
  output logic [EX_W-1:0]  ex_o,
  output logic [WB_W-1:0]  wb_q_o,
  output logic [MEM_W-1:0] mem_q_o,
  output logic [EX_W-1:0]  ex_q_o
);
  op_class_e cls;
  wb_ctl_t   wb_c;
  mem_ctl_t  mem_c;
  ex_ctl_t   ex_c;

  op_classify u_cls (
    .opcode_i (opcode_i),
    .class_o  (cls)
  );

  ctl_encode u_enc (
    .class_i (cls),
    .wb_o    (wb_c),
    .mem_o   (mem_c),
    .ex_o    (ex_c)
  );

  assign wb_o  = wb_c;
  assign mem_o = mem_c;
  assign ex_o  = ex_c;

  // control slice of the decode/execute pipeline register
  ctl_stage #(.W(CTL_W)) u_stage (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({wb_c, mem_c, ex_c}),
    .q_o    ({wb_q_o, mem_q_o, ex_q_o})
  );
endmodule

// File: rtl/op_ctrl_checker.sv
module op_ctrl_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [5:0] opcode_i,
  input logic [1:0] wb_o,
  input logic [2:0] mem_o,
  input logic [3:0] ex_o,
  input logic [1:0] wb_q_o,
  input logic [2:0] mem_q_o,
  input logic [3:0] ex_q_o
);
  p_nop_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    opcode_i == 6'b100000 |-> {wb_o, mem_o, ex_o} == 9'd0);

  p_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    opcode_i == 6'b100011 |-> {wb_o, mem_o, ex_o} == 9'b11_010_0001);

  p_beq_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    opcode_i == 6'b000100 |-> {wb_o, mem_o, ex_o} == 9'b00_100_0010);

  p_mem_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_o[1] && mem_o[0]) && !(mem_o[2] && wb_o[1]));

  p_stage_follow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> {wb_q_o, mem_q_o, ex_q_o} == $past({wb_o, mem_o, ex_o}));
endmodule

bind op_ctrl_decoder op_ctrl_checker u_chk (.*);

// File: tb/tb_op_ctrl_decoder.sv
module tb_op_ctrl_decoder;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] opc = 6'd0;
  logic [1:0] wb, wb_q;
  logic [2:0] mem, mem_q;
  logic [3:0] ex, ex_q;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  op_ctrl_decoder dut (
    .clk_i(clk), .rst_ni(rst_n), .opcode_i(opc),
    .wb_o(wb), .mem_o(mem), .ex_o(ex),
    .wb_q_o(wb_q), .mem_q_o(mem_q), .ex_q_o(ex_q)
  );

  // reference: {reg_write,mem_to_reg, branch,mem_read,mem_write, reg_dst,alu_op[1:0],alu_src}
  function automatic logic [8:0] ref_ctl(input logic [5:0] op);
    if (op == 6'd0)       return 9'b10_000_1100;
    if (op == 6'd35)      return 9'b11_010_0001;
    if (op == 6'd43)      return 9'b00_001_0001;
    if (op == 6'd4)       return 9'b00_100_0010;
    return 9'd0;
  endfunction

  function automatic string req_of(input logic [5:0] op);
    case (op)
      6'd0:  return "R2";
      6'd35: return "R3";
      6'd43: return "R4";
      6'd4:  return "R5";
      6'd32: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s opcode=%b actual=%b expected=%b", req, opc, act, exp);
    end
  endtask

  // drive at negedge, check comb a bit later, check registered copy after next posedge
  task automatic apply(input logic [5:0] op);
    logic [8:0] e;
    @(negedge clk);
    opc = op;
    #1;
    e = ref_ctl(op);
    check(req_of(op), {wb, mem, ex}, e);
    check("R9", {7'd0, mem[1] & mem[0], mem[2] & wb[1]}, 9'd0);
    @(posedge clk);
    #1;
    check("R8", {wb_q, mem_q, ex_q}, e);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    opc = 6'b100011;
    repeat (3) @(posedge clk);
    #1;
    check("R8", {wb_q, mem_q, ex_q}, 9'd0); // reset state
    @(negedge clk);
    rst_n = 1'b1;
    // R1 field positions exercised via each decoded opcode
    apply(6'b000000);
    apply(6'b100011);
    apply(6'b101011);
    apply(6'b000100);
    apply(6'b100000);
    apply(6'b100001);
    // full sweep, R7 for all non-decoded opcodes
    for (int i = 0; i < 64; i++) apply(6'(i));
    // back-to-back alternation
    for (int i = 0; i < 8; i++) begin
      apply(6'b100011);
      apply(6'b000100);
      apply(6'b101011);
    end
    // asynchronous clear mid-run
    apply(6'b100011);
    @(negedge clk);
    #2;
    rst_n = 1'b0;
    #1;
    check("R8", {wb_q, mem_q, ex_q}, 9'd0);
    @(posedge clk);
    #1;
    check("R8", {wb_q, mem_q, ex_q}, 9'd0);
    @(negedge clk);
    rst_n = 1'b1;
    apply(6'b000000);
    apply(6'b100000);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule